// File: doc/BRIEF.md
# Shared ADC/DAC Parallel Conversion Controller

This block sits between a simple register port and a pair of external converters that share a parallel data and address interface. Software starts an analogue-to-digital conversion by writing to the ADC data register. It starts a digital-to-analogue conversion by writing to the DAC data register. The converter answers each start with a single-cycle ready pulse.

One busy lock is shared by both directions. While a conversion of either kind is active, any further start request of either kind is dropped without notice. The data width in each direction can be set to 8, 12 or 16 bits. Converter data is masked to that width on the way in and on the way out.

Three 8-bit registers control the address pins: one holds the sampled input value, one holds the output value and one holds a per-bit direction.

Top module: `adda_conv_ctrl`

## Requirements
- R1: A write to register address 1 (ADC data) while no conversion is busy makes adc_start_o high for exactly the one cycle after the write's clock edge. From that edge on, a conversion is busy.
- R2: A write to address 1 or address 2 while a conversion of either kind is busy produces no start pulse. It also leaves the stored DAC value unchanged.
- R3: A conversion stays busy until cnv_ready_i is sampled high. At that edge the busy state clears and, for an ADC conversion, the result becomes adc_data_i masked to the ADC width then in force. A ready pulse while idle has no effect.
- R4: A read of address 1 returns the last latched ADC result. This holds during a later conversion that has not yet finished. The data written to address 1 is discarded.
- R5: The configuration register is at address 0. Bits [1:0] give the ADC width and bits [3:2] give the DAC width, with the encoding 00 = 8 bits, 01 = 12 bits, 1x = 16 bits. Reads return these four bits with all higher bits zero.
- R6: An accepted write to address 2 stores the value and makes dac_start_o high for the next cycle. While that DAC conversion is busy, dac_oe_o equals the low-bit mask of the DAC width and dac_data_o carries the stored value inside that mask. At every other time both outputs are zero.
- R7: A read of address 2 returns the stored DAC value masked to the DAC width currently configured, with all other bits zero.
- R8: Address 3 is read-only and holds addr_pad_i as sampled on every clock. Address 4 holds the output value and address 5 holds the direction, where 1 means output. All three are 8 bits wide and reset to zero. addr_oe_o equals the direction register, and addr_pad_o equals the output value gated by the direction.
- R9: Register reads are combinational from reg_addr_i. Addresses 6 and 7 read zero, and writes to addresses 3, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| adc_start_o | output | 1 | ADC conversion start pulse |
| dac_start_o | output | 1 | DAC conversion start pulse |
| cnv_ready_i | input | 1 | Converter done pulse |
| adc_data_i | input | 16 | Converter sample input |
| dac_data_o | output | 16 | DAC output data |
| dac_oe_o | output | 16 | Per-bit output enable of DAC data |
| addr_pad_i | input | 8 | Address pins, input side |
| addr_pad_o | output | 8 | Address pins, output side |
| addr_oe_o | output | 8 | Per-bit output enable of address pins |

## Verification
The hardest case to reach from the ports is a start request that lands on the same clock edge as the ready pulse that ends the current conversion. The request must still be rejected, because the lock is only released by that edge. A second hard case is a change of the DAC width in the middle of a DAC conversion, which must move the output enables at once.

Directed steps place a DAC write on the ready cycle and rewrite the configuration while a DAC conversion is busy. A long phase of random register traffic, with random ready pulses, is then compared cycle by cycle against a behavioural model, which produces many more such collisions.

// File: rtl/adda_pkg.sv
package adda_pkg;
  localparam int DATA_W   = 16;
  localparam int PADS_W   = 8;
  localparam int REG_AW   = 3;
  localparam int NARROW_W = 8;
  localparam int MID_W    = 12;
  localparam int SEL_W    = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CFG  = 3'd0,
    RA_ADC  = 3'd1,
    RA_DAC  = 3'd2,
    RA_AIN  = 3'd3,
    RA_AOUT = 3'd4,
    RA_ADIR = 3'd5
  } reg_addr_e;

  typedef enum logic {
    CONV_ADC = 1'b0,
    CONV_DAC = 1'b1
  } conv_kind_e;

  // Width selector to low-bit mask: 00 narrow, 01 mid, 1x full.
  function automatic logic [DATA_W-1:0] width_mask(input logic [SEL_W-1:0] sel);
    logic [DATA_W-1:0] m;
    int n;
    n = sel[1] ? DATA_W : (sel[0] ? MID_W : NARROW_W);
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/adda_lock.sv
module adda_lock
  import adda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_req_i,
  input  logic              dac_req_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] adc_din_i,
  input  logic [DATA_W-1:0] adc_mask_i,
  output logic              busy_o,
  output conv_kind_e        kind_o,
  output logic              adc_start_o,
  output logic              dac_start_o,
  output logic [DATA_W-1:0] adc_res_o,
  output logic [DATA_W-1:0] dac_val_o
);
  logic              busy_q;
  conv_kind_e        kind_q;
  logic              adc_start_q, dac_start_q;
  logic [DATA_W-1:0] adc_res_q, dac_val_q;

  // Named internal events
  logic adc_accept, dac_accept, conv_done;
  assign adc_accept = adc_req_i && !busy_q;
  assign dac_accept = dac_req_i && !busy_q;
  assign conv_done  = busy_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      kind_q      <= CONV_ADC;
      adc_start_q <= 1'b0;
      dac_start_q <= 1'b0;
      adc_res_q   <= '0;
      dac_val_q   <= '0;
    end else begin
      adc_start_q <= adc_accept;
      dac_start_q <= dac_accept;
      if (conv_done) begin
        busy_q <= 1'b0;
        if (kind_q == CONV_ADC) adc_res_q <= adc_din_i & adc_mask_i;
      end else if (adc_accept) begin
        busy_q <= 1'b1;
        kind_q <= CONV_ADC;
      end else if (dac_accept) begin
        busy_q    <= 1'b1;
        kind_q    <= CONV_DAC;
        dac_val_q <= wdata_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign kind_o      = kind_q;
  assign adc_start_o = adc_start_q;
  assign dac_start_o = dac_start_q;
  assign adc_res_o   = adc_res_q;
  assign dac_val_o   = dac_val_q;

  AST_ADC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req_i && !busy_q) |=> (adc_start_q && busy_q && kind_q == CONV_ADC)); // R1
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adc_start_q, dac_start_q})); // R2
  AST_REJECT_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req_i && busy_q) |=> !adc_start_q); // R2
  AST_REJECT_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_req_i && busy_q) |=> (!dac_start_q && $stable(dac_val_q))); // R2
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready_i) |=> !busy_q); // R3
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready_i) |=> busy_q); // R3
  AST_ADC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready_i && kind_q == CONV_ADC) |=> adc_res_q == $past(adc_din_i & adc_mask_i)); // R3
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && ready_i && !adc_req_i && !dac_req_i) |=> (!busy_q && $stable(adc_res_q))); // R3
  AST_DAC_START: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_req_i && !busy_q) |=> (dac_start_q && kind_q == CONV_DAC && dac_val_q == $past(wdata_i))); // R6
endmodule

// File: rtl/adda_regs.sv
module adda_regs
  import adda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [PADS_W-1:0] wdata_i,
  input  logic [PADS_W-1:0] pad_i,
  input  logic [DATA_W-1:0] adc_res_i,
  input  logic [DATA_W-1:0] dac_val_i,
  output logic [SEL_W-1:0]  adc_sel_o,
  output logic [SEL_W-1:0]  dac_sel_o,
  output logic [PADS_W-1:0] aout_o,
  output logic [PADS_W-1:0] adir_o,
  output logic              adc_req_o,
  output logic              dac_req_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CFG_W = 2 * SEL_W;

  logic [SEL_W-1:0]  adc_sel_q, dac_sel_q;
  logic [PADS_W-1:0] ain_q, aout_q, adir_q;

  logic cfg_wr, aout_wr, adir_wr;
  assign cfg_wr    = wr_i && (addr_i == RA_CFG);
  assign aout_wr   = wr_i && (addr_i == RA_AOUT);
  assign adir_wr   = wr_i && (addr_i == RA_ADIR);
  assign adc_req_o = wr_i && (addr_i == RA_ADC);
  assign dac_req_o = wr_i && (addr_i == RA_DAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_sel_q <= '0;
      dac_sel_q <= '0;
      ain_q     <= '0;
      aout_q    <= '0;
      adir_q    <= '0;
    end else begin
      ain_q <= pad_i;
      if (cfg_wr) begin
        adc_sel_q <= wdata_i[SEL_W-1:0];
        dac_sel_q <= wdata_i[CFG_W-1:SEL_W];
      end
      if (aout_wr) aout_q <= wdata_i;
      if (adir_wr) adir_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CFG:  rdata_o[CFG_W-1:0]  = {dac_sel_q, adc_sel_q};
      RA_ADC:  rdata_o             = adc_res_i;
      RA_DAC:  rdata_o             = dac_val_i & width_mask(dac_sel_q);
      RA_AIN:  rdata_o[PADS_W-1:0] = ain_q;
      RA_AOUT: rdata_o[PADS_W-1:0] = aout_q;
      RA_ADIR: rdata_o[PADS_W-1:0] = adir_q;
      default: rdata_o = '0;
    endcase
  end

  assign adc_sel_o = adc_sel_q;
  assign dac_sel_o = dac_sel_q;
  assign aout_o    = aout_q;
  assign adir_o    = adir_q;

  AST_AIN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ain_q == $past(pad_i)); // R8
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(adc_sel_q) && $stable(dac_sel_q))); // R5
endmodule

// File: rtl/adda_pads.sv
module adda_pads
  import adda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_active_i,
  input  logic [DATA_W-1:0] dac_val_i,
  input  logic [DATA_W-1:0] dac_mask_i,
  input  logic [PADS_W-1:0] aout_i,
  input  logic [PADS_W-1:0] adir_i,
  output logic [DATA_W-1:0] dac_data_o,
  output logic [DATA_W-1:0] dac_oe_o,
  output logic [PADS_W-1:0] addr_pad_o,
  output logic [PADS_W-1:0] addr_oe_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_dac_bit
    assign dac_oe_o[b]   = dac_active_i && dac_mask_i[b];
    assign dac_data_o[b] = dac_active_i && dac_mask_i[b] && dac_val_i[b];
  end

  for (genvar a = 0; a < PADS_W; a++) begin : g_addr_bit
    assign addr_oe_o[a]  = adir_i[a];
    assign addr_pad_o[a] = adir_i[a] && aout_i[a];
  end

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_active_i |-> (dac_oe_o == '0 && dac_data_o == '0)); // R6
  AST_DOUT_IN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_data_o & ~dac_oe_o) == '0); // R6
  AST_ADDR_IN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_pad_o & ~addr_oe_o) == '0); // R8
endmodule

// File: rtl/adda_conv_ctrl.sv
module adda_conv_ctrl
  import adda_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_i,
  input  logic [REG_AW-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic                    adc_start_o,
  output logic                    dac_start_o,
  input  logic                    cnv_ready_i,
  input  logic [DATA_W-1:0]       adc_data_i,
  output logic [DATA_W-1:0]       dac_data_o,
  output logic [DATA_W-1:0]       dac_oe_o,
  input  logic [PADS_W-1:0]       addr_pad_i,
  output logic [PADS_W-1:0]       addr_pad_o,
  output logic [PADS_W-1:0]       addr_oe_o
);
  logic [SEL_W-1:0]  adc_sel, dac_sel;
  logic [PADS_W-1:0] aout, adir;
  logic              adc_req, dac_req, busy;
  conv_kind_e        kind;
  logic [DATA_W-1:0] adc_res, dac_val, adc_mask, dac_mask;
  logic              dac_active;

  assign adc_mask   = width_mask(adc_sel);
  assign dac_mask   = width_mask(dac_sel);
  assign dac_active = busy && (kind == CONV_DAC);

  adda_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i[PADS_W-1:0]),
    .pad_i     (addr_pad_i),
    .adc_res_i (adc_res),
    .dac_val_i (dac_val),
    .adc_sel_o (adc_sel),
    .dac_sel_o (dac_sel),
    .aout_o    (aout),
    .adir_o    (adir),
    .adc_req_o (adc_req),
    .dac_req_o (dac_req),
    .rdata_o   (reg_rdata_o)
  );

  adda_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_req_i   (adc_req),
    .dac_req_i   (dac_req),
    .wdata_i     (reg_wdata_i),
    .ready_i     (cnv_ready_i),
    .adc_din_i   (adc_data_i),
    .adc_mask_i  (adc_mask),
    .busy_o      (busy),
    .kind_o      (kind),
    .adc_start_o (adc_start_o),
    .dac_start_o (dac_start_o),
    .adc_res_o   (adc_res),
    .dac_val_o   (dac_val)
  );

  adda_pads u_pads (
    .clk          (clk),
    .rst_n        (rst_n),
    .dac_active_i (dac_active),
    .dac_val_i    (dac_val),
    .dac_mask_i   (dac_mask),
    .aout_i       (aout),
    .adir_i       (adir),
    .dac_data_o   (dac_data_o),
    .dac_oe_o     (dac_oe_o),
    .addr_pad_o   (addr_pad_o),
    .addr_oe_o    (addr_oe_o)
  );

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == RA_ADC && !cnv_ready_i) |=> $stable(adc_res)); // R4
endmodule

// File: tb/tb_adda_conv_ctrl.sv
`timescale 1ns/1ps
module tb_adda_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        adc_start_o, dac_start_o;
  logic        cnv_ready_i = 1'b0;
  logic [15:0] adc_data_i = '0;
  logic [15:0] dac_data_o, dac_oe_o;
  logic [7:0]  addr_pad_i = 8'hFF;
  logic [7:0]  addr_pad_o, addr_oe_o;

  always #2 clk = ~clk;

  adda_conv_ctrl dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 1'b0;

  // Behavioural reference model
  bit          m_busy, m_dac_kind, m_as, m_ds;
  logic [15:0] m_adc, m_dac;
  logic [1:0]  m_asel, m_dsel;
  logic [7:0]  m_ain, m_aout, m_adir;

  function automatic logic [15:0] msk(input logic [1:0] s);
    if (s == 2'b00) return 16'h00FF;
    if (s == 2'b01) return 16'h0FFF;
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {12'h000, m_dsel, m_asel};
      3'd1: return m_adc;
      3'd2: return m_dac & msk(m_dsel);
      3'd3: return {8'h00, m_ain};
      3'd4: return {8'h00, m_aout};
      3'd5: return {8'h00, m_adir};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_dac_kind = 0; m_as = 0; m_ds = 0;
      m_adc = 0; m_dac = 0; m_asel = 0; m_dsel = 0;
      m_ain = 0; m_aout = 0; m_adir = 0;
    end else begin
      m_as = 0; m_ds = 0;
      m_ain = addr_pad_i;
      if (m_busy) begin
        if (cnv_ready_i) begin
          if (!m_dac_kind) m_adc = adc_data_i & msk(m_asel);
          m_busy = 0;
        end
      end else if (reg_wr_i && reg_addr_i == 3'd1) begin
        m_busy = 1; m_dac_kind = 0; m_as = 1;
      end else if (reg_wr_i && reg_addr_i == 3'd2) begin
        m_busy = 1; m_dac_kind = 1; m_ds = 1; m_dac = reg_wdata_i;
      end
      if (reg_wr_i) begin
        if (reg_addr_i == 3'd0) begin m_asel = reg_wdata_i[1:0]; m_dsel = reg_wdata_i[3:2]; end
        if (reg_addr_i == 3'd4) m_aout = reg_wdata_i[7:0];
        if (reg_addr_i == 3'd5) m_adir = reg_wdata_i[7:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [15:0] oe;
      oe = (m_busy && m_dac_kind) ? msk(m_dsel) : 16'h0000;
      case (reg_addr_i)
        3'd0: chk("R5 cfg read", reg_rdata_o, exp_read(reg_addr_i));
        3'd1: chk("R4 adc read", reg_rdata_o, exp_read(reg_addr_i));
        3'd2: chk("R7 dac read", reg_rdata_o, exp_read(reg_addr_i));
        3'd6, 3'd7: chk("R9 unused read", reg_rdata_o, exp_read(reg_addr_i));
        default: chk("R8 addr read", reg_rdata_o, exp_read(reg_addr_i));
      endcase
      chk("R1/R2 adc_start", {15'h0, adc_start_o}, {15'h0, m_as});
      chk("R6/R2 dac_start", {15'h0, dac_start_o}, {15'h0, m_ds});
      chk("R6 dac_oe", dac_oe_o, oe);
      chk("R6 dac_data", dac_data_o, m_dac & oe);
      chk("R8 addr_oe", {8'h00, addr_oe_o}, {8'h00, m_adir});
      chk("R8 addr_pad_o", {8'h00, addr_pad_o}, {8'h00, m_aout & m_adir});
    end
  end

  task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d, input logic r);
    @(posedge clk); #1;
    reg_wr_i = w; reg_addr_i = a; reg_wdata_i = d; cnv_ready_i = r;
  endtask

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  initial begin
    // Reset state, R8: address registers clear
    repeat (3) @(posedge clk);
    #1 reg_addr_i = 3'd4;
    @(negedge clk);
    chk("R8 reset aout", reg_rdata_o, 16'h0000);
    chk("R8 reset addr_oe", {8'h00, addr_oe_o}, 16'h0000);
    chk("R6 reset dac_oe", dac_oe_o, 16'h0000);
    reg_addr_i = 3'd5;
    #1 chk("R8 reset adir", reg_rdata_o, 16'h0000);
    @(posedge clk); #1 rst_n = 1'b1; cmp_on = 1'b1;

    // R5: ADC 12 bits, DAC 8 bits
    adc_data_i = 16'hABCD;
    step(1, 3'd0, 16'h0001, 0);
    step(1, 3'd1, 16'h1234, 0);   // R1 accepted
    step(1, 3'd2, 16'h7777, 0);   // R2 rejected while ADC busy
    step(1, 3'd1, 16'h0000, 0);   // R2 rejected
    step(0, 3'd0, 16'h0000, 0);
    step(1, 3'd2, 16'h5555, 1);   // R2 write on the ready edge is rejected, R3 done
    step(0, 3'd1, 16'h0000, 0);
    @(negedge clk);
    chk("R3 adc 12-bit result", reg_rdata_o, 16'h0BCD);
    #1 reg_addr_i = 3'd2;
    #1 chk("R2 dac unchanged", reg_rdata_o, 16'h0000);

    // R6/R7 DAC conversion, width changed mid-conversion
    step(1, 3'd2, 16'hBEEF, 0);
    step(0, 3'd2, 16'h0000, 0);
    @(negedge clk);
    chk("R6 dac_oe 8-bit", dac_oe_o, 16'h00FF);
    chk("R6 dac_data 8-bit", dac_data_o, 16'h00EF);
    chk("R7 dac read 8-bit", reg_rdata_o, 16'h00EF);
    step(1, 3'd0, 16'h0009, 0);   // ADC 12, DAC 16
    step(0, 3'd2, 16'h0000, 0);
    @(negedge clk);
    chk("R6 dac_oe 16-bit", dac_oe_o, 16'hFFFF);
    chk("R7 dac read 16-bit", reg_rdata_o, 16'hBEEF);
    step(1, 3'd1, 16'h0000, 0);   // R2 ADC rejected during DAC
    step(0, 3'd2, 16'h0000, 1);
    step(0, 3'd2, 16'h0000, 0);
    @(negedge clk);
    chk("R6 dac_oe idle", dac_oe_o, 16'h0000);
    chk("R2 no adc start", {15'h0, adc_start_o}, 16'h0000);

    // R4: read before completion returns the previous result; R3 16-bit
    step(1, 3'd0, 16'h000B, 0);
    adc_data_i = 16'h5A5A;
    step(1, 3'd1, 16'hFFFF, 0);
    step(0, 3'd1, 16'h0000, 0);
    @(negedge clk);
    chk("R1 adc_start pulse", {15'h0, adc_start_o}, 16'h0001);
    chk("R4 previous result", reg_rdata_o, 16'h0BCD);
    step(0, 3'd1, 16'h0000, 1);
    step(0, 3'd1, 16'h0000, 0);
    @(negedge clk);
    chk("R3 adc 16-bit result", reg_rdata_o, 16'h5A5A);

    // R5: 8-bit ADC width
    step(1, 3'd0, 16'h0008, 0);
    step(1, 3'd1, 16'h0000, 0);
    step(0, 3'd0, 16'h0000, 1);
    step(0, 3'd1, 16'h0000, 0);
    @(negedge clk);
    chk("R5 adc 8-bit result", reg_rdata_o, 16'h005A);
    step(0, 3'd0, 16'h0000, 0);
    @(negedge clk);
    chk("R5 cfg readback", reg_rdata_o, 16'h0008);

    // R8 address pins; R9 writes to 3 and 6 ignored
    step(1, 3'd4, 16'h00A5, 0);
    step(1, 3'd5, 16'h000F, 0);
    addr_pad_i = 8'h3C;
    step(1, 3'd3, 16'h00FF, 0);
    step(1, 3'd6, 16'hFFFF, 0);
    step(0, 3'd3, 16'h0000, 0);
    @(negedge clk);
    chk("R8 addr_pad_o", {8'h00, addr_pad_o}, 16'h0005);
    chk("R8 addr_oe", {8'h00, addr_oe_o}, 16'h000F);
    chk("R8 ain", reg_rdata_o, 16'h003C);
    #1 reg_addr_i = 3'd6;
    #1 chk("R9 unused reads zero", reg_rdata_o, 16'h0000);

    // Random traffic compared with the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2, r3;
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      step(r1[1:0] == 2'b00, r1[4:2], r2[15:0], r1[7:5] < 3'd2);
      adc_data_i = r2[31:16];
      addr_pad_i = r3[7:0];
    end
    step(0, 3'd0, 16'h0000, 0);
    @(negedge clk);
    summary_and_end();
  end
endmodule